// File: doc/BRIEF.md
# Scan Chain Enumeration Master

This block is the host side of a four-wire boundary-scan port. It generates the test clock by dividing the system clock, drives the mode-select and serial data lines, and samples the returning serial data. One start pulse runs the whole enumeration of an unknown daisy chain without further help. First every test access port in the chain is forced into its reset state, and the data registers that reset selects (the 32-bit identification words) are shifted out. Then every instruction register is filled with ones, which selects the one-bit bypass path in each device. Finally a single marker bit is timed through the chain.

The number of test-clock cycles the marker needs to come back equals the number of devices. When the run ends the block raises a done flag and holds the device count and the identification words it captured. If the marker does not return within a set number of cycles, a timeout flag is raised as well. At the end of every run the chain is left in its reset state and the test clock is left stopped low.

Top module: `scan_enum_master`

## Requirements
- R1: While rst_n is low and right after it, tck_o, tms_o and tdi_o are 0, busy_o, done_o and timeout_o are 0, and dev_count_o is 0.
- R2: While busy_o is high, tms_o and tdi_o change only in the system cycle where tck_o falls. Each high phase of tck_o lasts exactly HALF_DIV system cycles.
- R3: A start pulse received while idle makes tms_o 1 for the first RST_LEN rising edges of tck_o, and 0 for the edge that follows. RST_LEN is at least 5.
- R4: Starting from the first rising edge in Shift-DR, tdo_i is sampled on each rising edge while TDI is held at 1. Word k of id_words_o (bits 32k+31 down to 32k) holds the k-th group of 32 sampled bits, with the first sampled bit in bit 32k. Groups read past the end of the chain therefore read as all ones.
- R5: During the instruction load exactly IR_TOTAL rising edges occur in Shift-IR, all with tdi_o = 1, and tms_o is 1 on the last of them.
- R6: After flushing the bypass path with MAX_WAIT zeros, one 1 is driven for a single rising edge. dev_count_o is the number of further rising edges until tdo_i reads 1, and it ranges from 0 to MAX_WAIT.
- R7: If no 1 is seen on tdo_i within MAX_WAIT rising edges after the marker, the run ends with done_o = 1, timeout_o = 1 and dev_count_o = 0.
- R8: A start pulse received while busy_o is high has no effect. The run that is in progress keeps its length and its results.
- R9: Every run ends with RST_LEN rising edges at tms_o = 1, which leaves the chain in reset. done_o stays high and tck_o stays low until the next start. busy_o is low whenever done_o or timeout_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse that begins one enumeration run |
| tdo_i | input | 1 | Serial data returning from the end of the chain |
| tck_o | output | 1 | Divided test clock |
| tms_o | output | 1 | Mode-select line, changes on the falling edge of tck_o |
| tdi_o | output | 1 | Serial data into the chain, changes on the falling edge of tck_o |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run finished; held until the next start |
| timeout_o | output | 1 | The last run saw no marker return |
| dev_count_o | output | $clog2(MAX_WAIT+1) | Measured bypass delay, which is the device count |
| id_words_o | output | 32*MAX_DEV | Captured identification words, word 0 in the low bits |

## Verification
The bench sweeps chain lengths from one to MAX_WAIT devices, each device with a distinct identification word. This separates an off-by-one in the bypass count from a wrong order of words or bits in the ID buffer. A chain one device longer than MAX_WAIT and a chain whose return line is stuck at 0 both lead to the timeout path: the first still returns real IDs, the second returns all-zero words. The chain model starts in a non-reset state with bypass selected, so a short reset walk or a short instruction load shows up as wrong IDs or a wrong count. A second start pulse in the middle of a run must leave that run's length and results unchanged.

// File: rtl/scan_enum_pkg.sv
// Shared types for the scan chain enumeration master.
// Assumes: phases are visited strictly in declaration order except IDLE.
package scan_enum_pkg;

    // Phase of the enumeration program; each phase is a run of TCK bits.
    typedef enum logic [3:0] {
        PH_IDLE,     // no run in progress
        PH_RST,      // TMS high to force every TAP to reset
        PH_TO_SDR,   // walk reset -> Shift-DR
        PH_ID,       // shift identification words out
        PH_TO_SIR,   // walk Exit1-DR -> Shift-IR
        PH_IR,       // load all ones into the instruction registers
        PH_TO_SDR2,  // walk Exit1-IR -> Shift-DR (bypass selected)
        PH_FLUSH,    // clear the bypass flops with zeros
        PH_WAIT,     // send marker, count cycles until it returns
        PH_EXIT      // TMS high to leave the chain in reset
    } phase_e;

    localparam int ID_W = 32;

endpackage

// File: rtl/scan_tck_gen.sv
// Test clock generator.
// Divides clk so that each TCK half period lasts HALF_DIV system cycles and
// gives one-cycle strobes in the cycle where TCK rises or falls.
// Assumes: run_i comes from a register. When run_i drops while TCK is high,
// TCK completes its high phase and then stays low, without a strobe.
module scan_tck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] div_q;
    logic          tck_q;
    logic          term;
    logic          active;

    assign term   = (div_q == DW'(HALF_DIV - 1));
    assign active = run_i || tck_q;

    // Half-period counter and TCK toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            tck_q <= 1'b0;
        end else if (active) begin
            if (term) begin
                div_q <= '0;
                tck_q <= ~tck_q;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end else begin
            div_q <= '0;
        end
    end

    assign tck_o  = tck_q;
    assign rise_o = run_i && term && !tck_q;
    assign fall_o = run_i && term && tck_q;
endmodule

// File: rtl/scan_id_buf.sv
// Identification word buffer.
// A right-shifting register: each sampled bit enters at the top, so after
// WORDS*32 shifts the first bit received sits in bit 0 of word 0.
// Assumes: clear_i and shift_i are never high in the same cycle.
module scan_id_buf #(
    parameter int WORDS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear_i,
    input  logic                                 shift_i,
    input  logic                                 bit_i,
    output logic [WORDS*scan_enum_pkg::ID_W-1:0] words_o
);
    localparam int BITS = WORDS * scan_enum_pkg::ID_W;

    logic [BITS-1:0] buf_q;

    // Clear on launch, shift one sampled TDO bit in per TCK rise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            buf_q <= '0;
        end else if (shift_i) begin
            buf_q <= {bit_i, buf_q[BITS-1:1]};
        end
    end

    assign words_o = buf_q;
endmodule

// File: rtl/scan_seq.sv
// Enumeration sequencer.
// Runs the fixed bit program (reset, IDs, IR load, flush, marker, exit).
// On each TCK rise it advances the program and samples TDO. On each TCK fall
// it presents TMS and TDI for the next rise.
// Assumes: rise_i and fall_i are never high together; IR_TOTAL is the summed
// instruction register length of the chain; RST_LEN >= 5.
module scan_seq #(
    parameter int RST_LEN  = 5,
    parameter int IR_TOTAL = 12,
    parameter int MAX_DEV  = 4,
    parameter int MAX_WAIT = 8,
    parameter int KW       = $clog2(MAX_WAIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          tdo_i,
    output logic          tms_o,
    output logic          tdi_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          timeout_o,
    output logic [KW-1:0] count_o,
    output logic          launch_o,
    output logic          id_shift_o
);
    import scan_enum_pkg::*;

    localparam int ID_BITS = MAX_DEV * ID_W;
    localparam int MAX_A   = (ID_BITS > IR_TOTAL) ? ID_BITS : IR_TOTAL;
    localparam int MAX_B   = (RST_LEN > MAX_WAIT) ? RST_LEN : MAX_WAIT;
    localparam int MAXLEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAXLEN + 1);

    phase_e        phase_q, nxt_ph;
    logic [CW-1:0] cnt_q;
    logic          tms_q, tdi_q, done_q, timeout_q, miss_q;
    logic [KW-1:0] count_q;
    logic          tms_c, tdi_c, last;
    int            len;

    assign busy_o   = (phase_q != PH_IDLE);
    assign launch_o = start_i && !busy_o;
    assign last     = (cnt_q == CW'(len - 1));

    // Bit program: length, TMS/TDI value and successor of each phase.
    always_comb begin
        len    = 1;
        tms_c  = 1'b0;
        tdi_c  = 1'b0;
        nxt_ph = PH_IDLE;
        case (phase_q)
            PH_RST:     begin len = RST_LEN;  tms_c = 1'b1; nxt_ph = PH_TO_SDR; end
            PH_TO_SDR:  begin len = 4; tms_c = (cnt_q == CW'(1)); nxt_ph = PH_ID; end
            PH_ID:      begin len = ID_BITS;  tms_c = last; tdi_c = 1'b1; nxt_ph = PH_TO_SIR; end
            PH_TO_SIR:  begin len = 5; tms_c = (cnt_q < CW'(3)); nxt_ph = PH_IR; end
            PH_IR:      begin len = IR_TOTAL; tms_c = last; tdi_c = 1'b1; nxt_ph = PH_TO_SDR2; end
            PH_TO_SDR2: begin len = 4; tms_c = (cnt_q < CW'(2)); nxt_ph = PH_FLUSH; end
            PH_FLUSH:   begin len = MAX_WAIT; nxt_ph = PH_WAIT; end
            PH_WAIT:    begin len = MAX_WAIT + 1; tdi_c = (cnt_q == '0); nxt_ph = PH_EXIT; end
            PH_EXIT:    begin len = RST_LEN;  tms_c = 1'b1; nxt_ph = PH_IDLE; end
            default:    begin len = 1; end
        endcase
    end

    // Program counter, result capture and TMS/TDI output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            tms_q     <= 1'b0;
            tdi_q     <= 1'b0;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            miss_q    <= 1'b0;
            count_q   <= '0;
        end else if (launch_o) begin
            phase_q   <= PH_RST;
            cnt_q     <= '0;
            tms_q     <= 1'b1;
            tdi_q     <= 1'b0;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            miss_q    <= 1'b0;
            count_q   <= '0;
        end else if (rise_i) begin
            if (phase_q == PH_WAIT) begin
                if (tdo_i) begin
                    count_q <= KW'(cnt_q);
                    phase_q <= PH_EXIT;
                    cnt_q   <= '0;
                end else if (cnt_q == CW'(MAX_WAIT)) begin
                    miss_q  <= 1'b1;
                    phase_q <= PH_EXIT;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (last) begin
                phase_q <= nxt_ph;
                cnt_q   <= '0;
                if (phase_q == PH_EXIT) begin
                    done_q    <= 1'b1;
                    timeout_q <= miss_q;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (fall_i) begin
            tms_q <= tms_c;
            tdi_q <= tdi_c;
        end
    end

    assign tms_o      = tms_q;
    assign tdi_o      = tdi_q;
    assign done_o     = done_q;
    assign timeout_o  = timeout_q;
    assign count_o    = count_q;
    assign id_shift_o = rise_i && (phase_q == PH_ID);
endmodule

// File: rtl/scan_enum_master.sv
// Scan chain enumeration master (top).
// Connects the test clock generator, the sequencer and the ID buffer.
// Assumes: tdo_i is already synchronous to clk; HALF_DIV >= 1.
module scan_enum_master #(
    parameter int HALF_DIV = 2,
    parameter int RST_LEN  = 5,
    parameter int IR_TOTAL = 12,
    parameter int MAX_DEV  = 4,
    parameter int MAX_WAIT = 8,
    localparam int CNT_W   = $clog2(MAX_WAIT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  tdo_i,
    output logic                  tck_o,
    output logic                  tms_o,
    output logic                  tdi_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  timeout_o,
    output logic [CNT_W-1:0]      dev_count_o,
    output logic [32*MAX_DEV-1:0] id_words_o
);
    logic rise, fall, launch, id_shift;

    scan_tck_gen #(.HALF_DIV(HALF_DIV)) u_tck (
        .clk(clk), .rst_n(rst_n), .run_i(busy_o),
        .tck_o(tck_o), .rise_o(rise), .fall_o(fall)
    );

    scan_seq #(
        .RST_LEN(RST_LEN), .IR_TOTAL(IR_TOTAL), .MAX_DEV(MAX_DEV),
        .MAX_WAIT(MAX_WAIT), .KW(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rise_i(rise), .fall_i(fall), .tdo_i(tdo_i),
        .tms_o(tms_o), .tdi_o(tdi_o), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o), .count_o(dev_count_o),
        .launch_o(launch), .id_shift_o(id_shift)
    );

    scan_id_buf #(.WORDS(MAX_DEV)) u_ids (
        .clk(clk), .rst_n(rst_n), .clear_i(launch),
        .shift_i(id_shift), .bit_i(tdo_i), .words_o(id_words_o)
    );
endmodule

// File: rtl/scan_enum_checker.sv
// Protocol checker for scan_enum_master, attached with bind.
// Assumes: reset is asserted from time zero.
module scan_enum_checker #(
    parameter int MAX_WAIT = 8,
    parameter int CW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tck,
    input logic          tms,
    input logic          tdi,
    input logic          busy,
    input logic          done,
    input logic          timeout,
    input logic [CW-1:0] count
);
    // R2: TMS/TDI move only together with a TCK falling edge during a run.
    a_r2_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (!$stable(tms) || !$stable(tdi)))
        |-> (!tck && $past(tck)));

    // R7: a timeout is always reported together with done.
    a_r7_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (done && count == '0));

    // R6: a measured count never exceeds the wait limit.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !timeout) |-> (count <= CW'(MAX_WAIT)));

    // R9: status flags are clear while a run is in progress.
    a_r9_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !timeout));

    // R9: once idle with TCK low, TCK stays low.
    a_r9_tck_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tck) |=> !tck);
endmodule

bind scan_enum_master scan_enum_checker #(.MAX_WAIT(MAX_WAIT), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck_o), .tms(tms_o), .tdi(tdi_o),
    .busy(busy_o), .done(done_o), .timeout(timeout_o), .count(dev_count_o)
);

// File: tb/test_scan_enum_master.sv
// Bench: a behavioural chain of nd devices sharing one TAP state, swept over
// chain lengths, plus a broken chain and a start pulse during a run.
module test_scan_enum_master;
    localparam int HALF_DIV = 2;
    localparam int RST_LEN  = 5;
    localparam int IR_TOTAL = 12;
    localparam int MAX_DEV  = 4;
    localparam int MAX_WAIT = 8;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int MAXN     = 10;
    localparam int MAXL     = 32 * MAXN;

    typedef enum logic [3:0] {
        T_RESET, T_IDLE, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR,
        T_UPDDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPDIR
    } tap_e;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tdo;
    logic tck, tms, tdi, busy, done, timeout;
    logic [CNT_W-1:0]      count;
    logic [32*MAX_DEV-1:0] ids;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scan_enum_master #(
        .HALF_DIV(HALF_DIV), .RST_LEN(RST_LEN), .IR_TOTAL(IR_TOTAL),
        .MAX_DEV(MAX_DEV), .MAX_WAIT(MAX_WAIT)
    ) i_scan_enum_master (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tdo_i(tdo),
        .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .busy_o(busy),
        .done_o(done), .timeout_o(timeout), .dev_count_o(count),
        .id_words_o(ids)
    );

    // ---------------- chain model ----------------
    tap_e       st = T_SHDR;
    bit         byp = 1'b1;
    int         nd = 1;
    bit         broken = 1'b0;
    logic       chain [0:MAXL-1];
    logic [11:0] ir = '0;
    logic       tdo_m = 1'b0;
    int         rises, ir_shifts, ir_ones;
    logic [5:0] tms_first;

    function automatic logic [31:0] idv(input int i);
        return {4'(i + 1), 16'(16'h2100 + 16'(i) * 16'h0111), 11'(11'h0A5 + 11'(i)), 1'b1};
    endfunction

    function automatic tap_e tap_next(input tap_e s, input logic m);
        case (s)
            T_RESET: return m ? T_RESET : T_IDLE;
            T_IDLE:  return m ? T_SELDR : T_IDLE;
            T_SELDR: return m ? T_SELIR : T_CAPDR;
            T_CAPDR: return m ? T_EX1DR : T_SHDR;
            T_SHDR:  return m ? T_EX1DR : T_SHDR;
            T_EX1DR: return m ? T_UPDDR : T_PAUDR;
            T_PAUDR: return m ? T_EX2DR : T_PAUDR;
            T_EX2DR: return m ? T_UPDDR : T_SHDR;
            T_UPDDR: return m ? T_SELDR : T_IDLE;
            T_SELIR: return m ? T_RESET : T_CAPIR;
            T_CAPIR: return m ? T_EX1IR : T_SHIR;
            T_SHIR:  return m ? T_EX1IR : T_SHIR;
            T_EX1IR: return m ? T_UPDIR : T_PAUIR;
            T_PAUIR: return m ? T_EX2IR : T_PAUIR;
            T_EX2IR: return m ? T_UPDIR : T_SHIR;
            default: return m ? T_SELDR : T_IDLE;
        endcase
    endfunction

    initial for (int j = 0; j < MAXL; j++) chain[j] = 1'b0;

    always @(posedge tck) begin
        logic [31:0] w;
        int L;
        case (st)
            T_RESET: byp = 1'b0;
            T_CAPDR: begin
                if (byp) for (int j = 0; j < nd; j++) chain[j] = 1'b0;
                else for (int j = 0; j < 32 * nd; j++) begin
                    w = idv(j / 32);
                    chain[j] = w[j % 32];
                end
            end
            T_SHDR: begin
                L = byp ? nd : 32 * nd;
                for (int j = 0; j < L - 1; j++) chain[j] = chain[j + 1];
                chain[L - 1] = tdi;
            end
            T_CAPIR: ir = 12'h555;
            T_SHIR: begin
                ir = {tdi, ir[11:1]};
                ir_shifts++;
                if (tdi) ir_ones++;
            end
            T_UPDIR: byp = (ir == 12'hFFF);
            default: ;
        endcase
        if (rises < 6) tms_first[rises] = tms;
        rises++;
        st = tap_next(st, tms);
    end

    always @(negedge tck) begin
        if (st == T_SHDR) tdo_m = chain[0];
        else if (st == T_SHIR) tdo_m = ir[0];
    end

    assign tdo = broken ? 1'b0 : tdo_m;

    // ---------------- edge monitor (R2) ----------------
    logic p_tms = 1'b0, p_tdi = 1'b0, p_tck = 1'b0, p_busy = 1'b0;
    int hi_len = 0;
    int r2_bad = 0;
    always @(negedge clk) begin
        if (busy && p_busy && (tms !== p_tms || tdi !== p_tdi) && !(p_tck && !tck))
            r2_bad++;
        if (tck) hi_len++;
        if (p_tck && !tck) begin
            if (p_busy && hi_len != HALF_DIV) r2_bad++;
            hi_len = 0;
        end
        p_tms = tms; p_tdi = tdi; p_tck = tck; p_busy = busy;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog: run did not end (actual cycles=%0d expected<150000)", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int run_cycles;

    task automatic run_case(input int n, input bit brk, input bit poke);
        bit timed_out;
        nd = n; broken = brk;
        rises = 0; ir_shifts = 0; ir_ones = 0; tms_first = '0; r2_bad = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        run_cycles = 1;
        timed_out = 1'b0;
        while (!done) begin
            @(negedge clk);
            run_cycles++;
            if (poke && run_cycles == 300) start = 1'b1;
            if (poke && run_cycles == 301) start = 1'b0;
            if (run_cycles > 20000) begin timed_out = 1'b1; break; end
        end
        check(!timed_out, "R9 run ends", run_cycles, 20000);
        repeat (3 * HALF_DIV) @(negedge clk);
        check(tms_first[4:0] == 5'b11111 && tms_first[5] == 1'b0, "R3 reset walk",
              tms_first, 6'b011111);
        check(ir_shifts == IR_TOTAL && ir_ones == IR_TOTAL, "R5 IR load",
              ir_shifts * 100 + ir_ones, IR_TOTAL * 100 + IR_TOTAL);
        for (int k = 0; k < MAX_DEV; k++) begin
            logic [31:0] exp;
            exp = brk ? 32'h0 : (k < n ? idv(k) : 32'hFFFF_FFFF);
            check(ids[32*k +: 32] == exp, "R4 id word", ids[32*k +: 32], exp);
        end
        if (!brk && n <= MAX_WAIT) begin
            check(count == CNT_W'(n) && !timeout, "R6 device count", count, n);
        end else begin
            check(timeout && count == '0, "R7 timeout", {timeout, count}, {1'b1, CNT_W'(0)});
        end
        check(done && !busy && !tck && st == T_RESET, "R9 final state",
              {done, busy, tck, st}, {1'b1, 1'b0, 1'b0, T_RESET});
        check(r2_bad == 0, "R2 edge timing", r2_bad, 0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check(!tck && !tms && !tdi && !busy && !done && !timeout && count == '0,
              "R1 in reset", {tck, tms, tdi, busy, done, timeout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tck && !tms && !tdi && !busy && !done && !timeout && count == '0 && ids == '0,
              "R1 after reset", {tck, tms, tdi, busy, done, timeout}, 0);
        for (int n = 1; n <= MAX_WAIT + 1; n++) run_case(n, 1'b0, 1'b0);
        run_case(2, 1'b1, 1'b0);
        run_case(3, 1'b0, 1'b0);
        base = run_cycles;
        run_case(3, 1'b0, 1'b1);
        check(run_cycles == base, "R8 start while busy", run_cycles, base);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule